// File: doc/BRIEF.md
# Video DMA Instruction Sequencer

This block runs a small program that tells a capture engine where to store incoming video pixel bytes. Each instruction is a pair of 32-bit words, a command word and then an address word. The sequencer fetches both words over a simple read port, decodes them, and acts on them. It can wait for the start of an odd or an even field, jump to another program location, or move a counted run of pixel bytes to a memory address.

A scan line that does not fit one contiguous memory chunk is handled as a sequence. A line-start instruction opens the line and writes the first piece. One or more in-line instructions follow, each with its own address and its own starting byte position inside the line. Every byte leaves on the write port with its address, its position in the line, the data type and the byte count of its instruction. The first byte of a line-start run is flagged.

Software sets a base address and pulses `start`. The program then runs until `stop` takes effect or an illegal instruction halts it with the error flag raised. An instruction can request an interrupt pulse when it completes.

Top module: `vid_dma_seq`

## Requirements
- R1: After reset, `busy`, `err`, `irq`, `pm_req`, `px_ready` and `wr_valid` are all low.
- R2: A `start` pulse while idle fetches the command word at `base_addr` and then the address word at `base_addr`+4. The next instruction's fetch begins 8 bytes further on. Each request holds `pm_req` and `pm_addr` steady until `pm_rvalid` answers it.
- R3: A command word whose bit 31 is clear, or whose opcode in bits 30:28 is 5, 6 or 7, halts the sequencer. `busy` drops, `err` rises and no further fetch happens. `err` stays high until the next `start`, which clears it.
- R4: Opcode 0 (sync-odd) waits for an `fld_odd` pulse that arrives while it waits. Opcode 1 (sync-even) waits for `fld_even` in the same way. The other field strobe has no effect on the wait, and the address word of a sync instruction is ignored.
- R5: Opcode 2 (jump) continues execution at the byte address held in its address word.
- R6: Opcode 3 (line-start) and opcode 4 (in-line) write N bytes, where N is command bits 11:0. Byte i goes to address word + i, with line position bits 23:12 + i. `wr_typ` carries bits 26:24 and `wr_cnt` carries N. `wr_sol` is high only on the first byte of a line-start run.
- R7: A pixel byte is taken only while a line-start or in-line run is active, one byte per cycle in which both `px_valid` and `px_ready` are high. A run with N = 0 completes at once and takes no byte.
- R8: An instruction with command bit 27 set gives exactly one single-cycle `irq` pulse when it completes. Other instructions give none.
- R9: A `stop` pulse ends a sync wait at once. During a fetch or a byte run, it takes effect when that instruction completes, without raising `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at base_addr (honoured while idle) |
| base_addr | input | AW | Byte address of the first instruction |
| stop | input | 1 | Request to halt |
| pm_req | output | 1 | Program word read request |
| pm_addr | output | AW | Byte address of the requested program word |
| pm_rvalid | input | 1 | Program word returned |
| pm_rdata | input | 32 | Returned program word |
| fld_odd | input | 1 | Odd field start strobe |
| fld_even | input | 1 | Even field start strobe |
| px_valid | input | 1 | Pixel byte available |
| px_data | input | PX_W | Pixel byte |
| px_ready | output | 1 | Sequencer takes pixel bytes |
| wr_valid | output | 1 | Memory write of one byte this cycle |
| wr_addr | output | AW | Byte write address |
| wr_data | output | PX_W | Byte write data |
| wr_cnt | output | 12 | Byte count of the current run |
| wr_pos | output | 12 | Position of this byte within the scan line |
| wr_typ | output | 3 | Data type of the current run |
| wr_sol | output | 1 | First byte of a line-start run |
| irq | output | 1 | Completion interrupt pulse |
| err | output | 1 | Halted on an illegal instruction |
| busy | output | 1 | Program running |

## Verification
The assertions check these properties on every cycle:
- a program read request holds until it is answered;
- pixels are accepted only during a byte run;
- a halted sequencer issues no fetch;
- interrupt pulses last one cycle;
- a sync instruction never leaves its wait without its own strobe or a stop.

Only the bench scenarios can show the values that must come out. These are the exact fetch address order across a jump, the addresses, positions and data of the bytes of a split line, and the number of interrupts. They also include the cases where nothing may happen: the wrong field strobe, a zero-length run, pixels offered outside a run, and the choice between a prompt stop and a stop deferred to the next boundary.

// File: rtl/vid_dma_pkg.sv
package vid_dma_pkg;
   localparam int WORD_W     = 32;
   localparam int INSN_BYTES = 8;
   localparam int CNT_W      = 12;
   localparam int POS_W      = 12;
   localparam int TYP_W      = 3;
   localparam int OPC_W      = 3;

   localparam int B_LEGAL  = 31;
   localparam int B_OPC_LO = 28;
   localparam int B_IRQ    = 27;
   localparam int B_TYP_LO = 24;
   localparam int B_POS_LO = 12;
   localparam int B_CNT_LO = 0;

   localparam logic [OPC_W-1:0] OPC_SYNC_ODD  = 3'd0;
   localparam logic [OPC_W-1:0] OPC_SYNC_EVEN = 3'd1;
   localparam logic [OPC_W-1:0] OPC_JUMP      = 3'd2;
   localparam logic [OPC_W-1:0] OPC_LINE      = 3'd3;
   localparam logic [OPC_W-1:0] OPC_CONT      = 3'd4;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_SYNC,
      SQ_MOVE
   } seq_state_e;

   typedef struct packed {
      logic             legal;
      logic [OPC_W-1:0] opc;
      logic             irq;
      logic [TYP_W-1:0] typ;
      logic [POS_W-1:0] pos;
      logic [CNT_W-1:0] cnt;
   } insn_t;
endpackage

// File: rtl/vid_dma_decode.sv
module vid_dma_decode
   import vid_dma_pkg::*;
(
   input  logic [WORD_W-1:0] cmd_word,
   output insn_t             insn
);
   logic [OPC_W-1:0] opc_f;

   assign opc_f = cmd_word[B_OPC_LO +: OPC_W];

   always_comb begin
      insn.opc   = opc_f;
      insn.legal = cmd_word[B_LEGAL] && (opc_f <= OPC_CONT);
      insn.irq   = cmd_word[B_IRQ];
      insn.typ   = cmd_word[B_TYP_LO +: TYP_W];
      insn.pos   = cmd_word[B_POS_LO +: POS_W];
      insn.cnt   = cmd_word[B_CNT_LO +: CNT_W];
   end
endmodule

// File: rtl/vid_dma_fetch.sv
module vid_dma_fetch
   import vid_dma_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [AW-1:0]     go_pc,
   output logic              pm_req,
   output logic [AW-1:0]     pm_addr,
   input  logic              pm_rvalid,
   input  logic [WORD_W-1:0] pm_rdata,
   output logic              done,
   output logic [WORD_W-1:0] cmd_word,
   output logic [WORD_W-1:0] arg_word
);
   localparam logic [AW-1:0] WORD_STEP = AW'(WORD_W / 8);

   typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_ARG} phase_e;

   phase_e phase;

   generate
      if (AW < 8 || AW > WORD_W) begin : g_bad_aw
         $error("vid_dma_fetch: AW must lie in 8..32");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         pm_addr  <= '0;
         cmd_word <= '0;
         arg_word <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (go) begin
                  phase   <= PH_CMD;
                  pm_addr <= go_pc;
               end
            end
            PH_CMD: begin
               if (pm_rvalid) begin
                  cmd_word <= pm_rdata;
                  pm_addr  <= pm_addr + WORD_STEP;
                  phase    <= PH_ARG;
               end
            end
            PH_ARG: begin
               if (pm_rvalid) begin
                  arg_word <= pm_rdata;
                  phase    <= PH_IDLE;
                  done     <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign pm_req = (phase != PH_IDLE);

   // R2: an outstanding read keeps its request and address
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_req && !pm_rvalid) |=> (pm_req && $stable(pm_addr)));

   // R2: the completion strobe lasts one cycle
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/vid_dma_mover.sv
module vid_dma_mover
   import vid_dma_pkg::*;
#(
   parameter int AW   = 32,
   parameter int PX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    ld_addr,
   input  logic [POS_W-1:0] ld_pos,
   input  logic [CNT_W-1:0] ld_cnt,
   input  logic [TYP_W-1:0] ld_typ,
   input  logic             ld_sol,
   input  logic             px_valid,
   input  logic [PX_W-1:0]  px_data,
   output logic             px_ready,
   output logic             wr_valid,
   output logic [AW-1:0]    wr_addr,
   output logic [PX_W-1:0]  wr_data,
   output logic [CNT_W-1:0] wr_cnt,
   output logic [POS_W-1:0] wr_pos,
   output logic [TYP_W-1:0] wr_typ,
   output logic             wr_sol,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

   logic             active;
   logic [CNT_W-1:0] left;
   logic             hs;

   generate
      if (PX_W < 1 || PX_W > 64) begin : g_bad_px
         $error("vid_dma_mover: PX_W must lie in 1..64");
      end
   endgenerate

   assign hs   = active && px_valid;
   assign done = hs && (left == ONE_LEFT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         left    <= '0;
         wr_addr <= '0;
         wr_pos  <= '0;
         wr_cnt  <= '0;
         wr_typ  <= '0;
         wr_sol  <= 1'b0;
      end else if (load) begin
         active  <= 1'b1;
         left    <= ld_cnt;
         wr_addr <= ld_addr;
         wr_pos  <= ld_pos;
         wr_cnt  <= ld_cnt;
         wr_typ  <= ld_typ;
         wr_sol  <= ld_sol;
      end else if (hs) begin
         left    <= left - ONE_LEFT;
         wr_addr <= wr_addr + AW'(1);
         wr_pos  <= wr_pos + POS_W'(1);
         wr_sol  <= 1'b0;
         if (left == ONE_LEFT) active <= 1'b0;
      end
   end

   assign px_ready = active;
   assign wr_valid = hs;
   assign wr_data  = px_data;

   // R7: a new run is never loaded over an unfinished one
   a_r7_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !px_ready);

   // R6: the final byte closes the run
   a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !px_ready);

   // R6: without a byte, address and position do not move
   a_r6_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (px_ready && !px_valid) |=> ($stable(wr_addr) && $stable(wr_pos)));
endmodule

// File: rtl/vid_dma_seq.sv
module vid_dma_seq
   import vid_dma_pkg::*;
#(
   parameter int AW      = 32,
   parameter int PX_W    = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     base_addr,
   input  logic              stop,
   output logic              pm_req,
   output logic [AW-1:0]     pm_addr,
   input  logic              pm_rvalid,
   input  logic [WORD_W-1:0] pm_rdata,
   input  logic              fld_odd,
   input  logic              fld_even,
   input  logic              px_valid,
   input  logic [PX_W-1:0]   px_data,
   output logic              px_ready,
   output logic              wr_valid,
   output logic [AW-1:0]     wr_addr,
   output logic [PX_W-1:0]   wr_data,
   output logic [CNT_W-1:0]  wr_cnt,
   output logic [POS_W-1:0]  wr_pos,
   output logic [TYP_W-1:0]  wr_typ,
   output logic              wr_sol,
   output logic              irq,
   output logic              err,
   output logic              busy
);
   localparam logic [AW-1:0] PC_STEP = AW'(INSN_BYTES);

   seq_state_e        st, st_nx;
   logic [AW-1:0]     pc, pc_nx;
   logic              stop_pend;
   logic              f_go, f_done;
   logic [WORD_W-1:0] f_cmd, f_arg;
   insn_t             insn;
   logic [AW-1:0]     arg_addr;
   logic              fin, ld, set_err, fld_hit, is_jump;

   generate
      if (AW < 8 || AW > WORD_W) begin : g_bad_aw
         $error("vid_dma_seq: AW must lie in 8..32");
      end
   endgenerate

   vid_dma_fetch #(.AW(AW)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (f_go),
      .go_pc    (pc_nx),
      .pm_req   (pm_req),
      .pm_addr  (pm_addr),
      .pm_rvalid(pm_rvalid),
      .pm_rdata (pm_rdata),
      .done     (f_done),
      .cmd_word (f_cmd),
      .arg_word (f_arg)
   );

   vid_dma_decode u_dec (
      .cmd_word(f_cmd),
      .insn    (insn)
   );

   assign arg_addr = f_arg[AW-1:0];
   assign fld_hit  = (insn.opc == OPC_SYNC_ODD) ? fld_odd : fld_even;
   assign is_jump  = (insn.opc == OPC_JUMP);

   always_comb begin
      st_nx   = st;
      pc_nx   = pc;
      f_go    = 1'b0;
      ld      = 1'b0;
      fin     = 1'b0;
      set_err = 1'b0;
      case (st)
         SQ_IDLE: begin
            if (start) begin
               pc_nx = base_addr;
               f_go  = 1'b1;
               st_nx = SQ_FETCH;
            end
         end
         SQ_FETCH: begin
            if (f_done) begin
               if (!insn.legal) begin
                  set_err = 1'b1;
                  st_nx   = SQ_IDLE;
               end else begin
                  case (insn.opc)
                     OPC_SYNC_ODD, OPC_SYNC_EVEN: st_nx = SQ_SYNC;
                     OPC_JUMP: fin = 1'b1;
                     default: begin
                        if (insn.cnt == '0) begin
                           fin = 1'b1;
                        end else begin
                           ld    = 1'b1;
                           st_nx = SQ_MOVE;
                        end
                     end
                  endcase
               end
            end
         end
         SQ_SYNC: begin
            if (stop || stop_pend) st_nx = SQ_IDLE;
            else if (fld_hit)      fin   = 1'b1;
         end
         SQ_MOVE: begin
            fin = u_mov_done;
         end
         default: st_nx = SQ_IDLE;
      endcase
      if (fin) begin
         pc_nx = (st == SQ_FETCH && is_jump) ? arg_addr : pc + PC_STEP;
         if (stop || stop_pend) begin
            st_nx = SQ_IDLE;
         end else begin
            f_go  = 1'b1;
            st_nx = SQ_FETCH;
         end
      end
   end

   logic u_mov_done;

   vid_dma_mover #(.AW(AW), .PX_W(PX_W)) u_mov (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld),
      .ld_addr (arg_addr),
      .ld_pos  (insn.pos),
      .ld_cnt  (insn.cnt),
      .ld_typ  (insn.typ),
      .ld_sol  (insn.opc == OPC_LINE),
      .px_valid(px_valid),
      .px_data (px_data),
      .px_ready(px_ready),
      .wr_valid(wr_valid),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_cnt  (wr_cnt),
      .wr_pos  (wr_pos),
      .wr_typ  (wr_typ),
      .wr_sol  (wr_sol),
      .done    (u_mov_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         pc        <= '0;
         stop_pend <= 1'b0;
         err       <= 1'b0;
      end else begin
         st        <= st_nx;
         pc        <= pc_nx;
         stop_pend <= (st_nx == SQ_IDLE) ? 1'b0 : (stop_pend || stop);
         if (st == SQ_IDLE && start) err <= 1'b0;
         else if (set_err)           err <= 1'b1;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= fin && insn.irq;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = fin && insn.irq;
      end
   endgenerate

   assign busy = (st != SQ_IDLE);

   // R3: a halted sequencer is idle and fetches nothing
   a_r3_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !pm_req));

   // R7: pixels are taken only during a byte run
   a_r7_ready_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      px_ready |-> (st == SQ_MOVE));

   // R8: interrupt is a single-cycle pulse
   a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R4: sync-odd stays waiting without its strobe or a stop
   a_r4_odd_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_SYNC && insn.opc == OPC_SYNC_ODD && !fld_odd && !stop && !stop_pend)
      |=> (st == SQ_SYNC));

   // R4: sync-even stays waiting without its strobe or a stop
   a_r4_even_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_SYNC && insn.opc == OPC_SYNC_EVEN && !fld_even && !stop && !stop_pend)
      |=> (st == SQ_SYNC));
endmodule

// File: tb/sim_vid_dma_seq.sv
`timescale 1ns/1ps
module sim_vid_dma_seq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start, stop, fld_odd, fld_even;
   logic [31:0] base_addr;
   logic        pm_req, pm_rvalid;
   logic [31:0] pm_addr, pm_rdata;
   logic        px_valid, px_ready;
   logic [7:0]  px_data;
   logic        wr_valid, wr_sol, irq, err, busy;
   logic [31:0] wr_addr;
   logic [7:0]  wr_data;
   logic [11:0] wr_cnt, wr_pos;
   logic [2:0]  wr_typ;

   always #2 clk = ~clk;

   vid_dma_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .stop(stop),
      .pm_req(pm_req), .pm_addr(pm_addr), .pm_rvalid(pm_rvalid), .pm_rdata(pm_rdata),
      .fld_odd(fld_odd), .fld_even(fld_even),
      .px_valid(px_valid), .px_data(px_data), .px_ready(px_ready),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_cnt(wr_cnt),
      .wr_pos(wr_pos), .wr_typ(wr_typ), .wr_sol(wr_sol),
      .irq(irq), .err(err), .busy(busy)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [11:0] pos;
      logic [7:0]  data;
      logic [2:0]  typ;
      logic        sol;
      logic [11:0] cnt;
   } wr_item_t;

   logic [31:0] mem [0:255];
   wr_item_t    exp_wr[$];
   logic [31:0] exp_fa[$];
   int n_chk = 0, n_bad = 0, n_wr = 0, irq_cnt = 0;
   int unsigned pix = 0, exp_pix = 0, cyc = 0;
   logic px_en = 1'b1, gap_en = 1'b1;
   bit finished = 1'b0;

   assign px_data = pix[7:0];

   // program memory: one word per request, answered a cycle later
   always @(posedge clk) begin
      if (!rst_n) begin
         pm_rvalid <= 1'b0;
         pm_rdata  <= '0;
      end else begin
         pm_rvalid <= pm_req && !pm_rvalid;
         pm_rdata  <= mem[pm_addr[9:2]];
      end
   end

   // pixel source with optional gaps
   always @(posedge clk) begin
      if (!rst_n) begin
         pix      <= 0;
         px_valid <= 1'b0;
         cyc      <= 0;
      end else begin
         cyc <= cyc + 1;
         if (px_valid && px_ready) pix <= pix + 1;
         px_valid <= px_en && (!gap_en || (cyc[0] ^ cyc[2]));
      end
   end

   task automatic chk(input bit ok, input string tag, input [63:0] act, input [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: fetch order and written bytes against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (pm_req && pm_rvalid) begin
            if (exp_fa.size() == 0) chk(1'b0, "R2 unexpected fetch", pm_addr, 0);
            else begin
               logic [31:0] e;
               e = exp_fa.pop_front();
               chk(pm_addr == e, "R2 fetch address", pm_addr, e);
            end
         end
         if (wr_valid) begin
            wr_item_t g;
            g = '{addr: wr_addr, pos: wr_pos, data: wr_data, typ: wr_typ, sol: wr_sol, cnt: wr_cnt};
            n_wr++;
            if (exp_wr.size() == 0) chk(1'b0, "R6 unexpected write", g[63:0], 0);
            else begin
               wr_item_t e;
               e = exp_wr.pop_front();
               chk(g == e, "R6 write item", g[63:0], e[63:0]);
            end
         end
         if (irq) irq_cnt++;
      end
   end

   function automatic logic [31:0] mk(input logic [2:0] op, input bit ir, input logic [2:0] ty,
                                      input logic [11:0] ps, input logic [11:0] ct);
      return {1'b1, op, ir, ty, ps, ct};
   endfunction

   task automatic put(input int a, input logic [31:0] c, input logic [31:0] g);
      mem[a >> 2]       = c;
      mem[(a >> 2) + 1] = g;
   endtask

   task automatic exp_fetch(input logic [31:0] a);
      exp_fa.push_back(a);
      exp_fa.push_back(a + 4);
   endtask

   task automatic exp_move(input logic [31:0] a, input logic [11:0] p, input int n,
                           input logic [2:0] t, input bit s);
      for (int i = 0; i < n; i++) begin
         exp_wr.push_back('{addr: a + i, pos: p + 12'(i), data: exp_pix[7:0], typ: t,
                            sol: s && (i == 0), cnt: 12'(n)});
         exp_pix++;
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go(input logic [31:0] a);
      base_addr = a;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic pulse_odd();
      @(negedge clk) fld_odd = 1'b1;
      @(negedge clk) fld_odd = 1'b0;
   endtask

   task automatic pulse_even();
      @(negedge clk) fld_even = 1'b1;
      @(negedge clk) fld_even = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk) stop = 1'b1;
      @(negedge clk) stop = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 2000 && (exp_fa.size() != 0 || exp_wr.size() != 0); i++)
         @(negedge clk);
      wait_n(10);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; stop = 1'b0; fld_odd = 1'b0; fld_even = 1'b0;
      base_addr = '0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      wait_n(5);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !err && !irq, "R1 busy/err/irq low", {busy, err, irq}, 0);
      chk(!pm_req && !px_ready && !wr_valid, "R1 req/ready/valid low", {pm_req, px_ready, wr_valid}, 0);

      // program A: split line, zero run, jump, field waits, illegal opcode
      put(32'h100, mk(3'd0, 1, 3'd0, 12'h0, 12'd0), 32'hDEAD);
      put(32'h108, mk(3'd3, 0, 3'd2, 12'h0, 12'd5), 32'h1000);
      put(32'h110, mk(3'd4, 1, 3'd2, 12'h5, 12'd3), 32'h2000);
      put(32'h118, mk(3'd3, 1, 3'd0, 12'h0, 12'd0), 32'h4000);
      put(32'h120, mk(3'd2, 0, 3'd0, 12'h0, 12'd0), 32'h140);
      put(32'h128, 32'h0, 32'h0);
      put(32'h140, mk(3'd1, 0, 3'd0, 12'h0, 12'd0), 32'h0);
      put(32'h148, mk(3'd3, 1, 3'd1, 12'h10, 12'd4), 32'h3000);
      put(32'h150, {1'b1, 3'd6, 28'h0}, 32'h0);
      exp_fetch(32'h100);
      go(32'h100);
      wait_n(40);
      chk(n_wr == 0, "R4 sync-odd stalls", n_wr, 0);
      chk(pix == 0, "R7 no pixel taken while waiting", pix, 0);
      chk(busy, "R4 still busy in wait", busy, 1);
      pulse_even();
      wait_n(20);
      chk(n_wr == 0, "R4 even strobe ignored by sync-odd", n_wr, 0);
      exp_fetch(32'h108); exp_move(32'h1000, 12'h0, 5, 3'd2, 1'b1);
      exp_fetch(32'h110); exp_move(32'h2000, 12'h5, 3, 3'd2, 1'b0);
      exp_fetch(32'h118); exp_fetch(32'h120); exp_fetch(32'h140);
      pulse_odd();
      drain();
      chk(n_wr == 8, "R6 split line byte total", n_wr, 8);
      chk(pix == 8, "R7 zero-count run takes no byte", pix, 8);
      chk(irq_cnt == 3, "R8 interrupts so far", irq_cnt, 3);
      chk(exp_fa.size() == 0, "R5 jump skips illegal word", exp_fa.size(), 0);
      pulse_odd();
      wait_n(20);
      chk(n_wr == 8, "R4 odd strobe ignored by sync-even", n_wr, 8);
      exp_fetch(32'h148); exp_move(32'h3000, 12'h10, 4, 3'd1, 1'b1);
      exp_fetch(32'h150);
      pulse_even();
      for (int i = 0; i < 500 && !err; i++) @(negedge clk);
      wait_n(5);
      chk(err, "R3 illegal opcode raises err", err, 1);
      chk(!busy, "R3 halted", busy, 0);
      chk(irq_cnt == 4, "R8 total interrupts", irq_cnt, 4);
      chk(pix == 12, "R7 pixel total", pix, 12);
      chk(exp_wr.size() == 0, "R6 all bytes written", exp_wr.size(), 0);
      chk(!px_ready, "R3 no pixel intake when halted", px_ready, 0);

      // program B: bit 31 clear
      put(32'h200, 32'h7000_0000, 32'h0);
      exp_fetch(32'h200);
      go(32'h200);
      chk(!err, "R3 start clears err", err, 0);
      for (int i = 0; i < 500 && !err; i++) @(negedge clk);
      wait_n(10);
      chk(err, "R3 clear bit 31 raises err", err, 1);
      chk(n_wr == 12 && irq_cnt == 4, "R3 no write or irq", {n_wr, irq_cnt}, {32'd12, 32'd4});
      chk(exp_fa.size() == 0, "R3 no fetch after halt", exp_fa.size(), 0);

      // program C: loop; stop during a field wait
      put(32'h300, mk(3'd0, 0, 3'd0, 12'h0, 12'd0), 32'h0);
      put(32'h308, mk(3'd3, 0, 3'd0, 12'h0, 12'd2), 32'h5000);
      put(32'h310, mk(3'd2, 0, 3'd0, 12'h0, 12'd0), 32'h300);
      exp_fetch(32'h300);
      go(32'h300);
      wait_n(20);
      exp_fetch(32'h308); exp_move(32'h5000, 12'h0, 2, 3'd0, 1'b1);
      exp_fetch(32'h310); exp_fetch(32'h300);
      pulse_odd();
      drain();
      chk(busy, "R5 loop back waits again", busy, 1);
      pulse_stop();
      wait_n(3);
      chk(!busy, "R9 stop ends field wait", busy, 0);
      chk(!err, "R9 stop leaves err low", err, 0);

      // stop during a run waits for the boundary
      px_en = 1'b0;
      wait_n(3);
      exp_fetch(32'h300);
      go(32'h300);
      wait_n(20);
      exp_fetch(32'h308);
      pulse_odd();
      wait_n(20);
      chk(px_ready, "R7 run waits for pixels", px_ready, 1);
      pulse_stop();
      wait_n(10);
      chk(busy, "R9 stop deferred during run", busy, 1);
      exp_move(32'h5000, 12'h0, 2, 3'd0, 1'b1);
      px_en = 1'b1;
      drain();
      chk(!busy, "R9 halted at boundary", busy, 0);
      chk(exp_fa.size() == 0 && exp_wr.size() == 0, "R9 no fetch past boundary",
          exp_fa.size(), 0);
      chk(!px_ready && !err, "R9 idle without err", {px_ready, err}, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule